// File: doc/BRIEF.md
# Firmware Glue Register Bank

A small memory-mapped slave that gives boot firmware on a multiprocessor platform a handful of services the operating system never touches. It offers a halt request with an 8-bit exit code, the identity of the processor issuing the access, the number of active processors, and a register that drives any one processor's level-sensitive interrupt line high or low. It also holds a one-character console port: a receive side that samples an external character source and a transmit side that emits a byte strobe.

The bus side is a single-cycle request: a read or write strobe, an address, a byte-size code, write data, and the index of the requesting processor. Read data appears, registered, in the cycle after the read strobe. Only the low six address bits are decoded, so the bank repeats every 64 bytes of address space. Write data byte 0 sits in bits 7:0 and byte 1 in bits 15:8. Read values are returned zero-extended in the low bits.

Offsets: 0x00 halt (write), 0x04 processor index (read), 0x08 interrupt drive (write), 0x0C processor count (read), 0x10 receive data (read/write), 0x14 receive status (read), 0x18 transmit data (read/write), 0x1C transmit status (read/write).

Top module: `fw_glue_regs`

## Requirements
- R1: Only address bits 5:0 are decoded; an access with any upper address bits behaves exactly as the same access at its low-6-bit offset.
- R2: A write to offset 0x00 produces `halt_pulse` high for exactly the one cycle after the write and sets `exit_code` to write data bits 7:0, held until the next such write.
- R3: A read of offset 0x04 returns `bus_cpu`, the index of the requesting processor, as sampled with the read strobe.
- R4: A read of offset 0x0C returns `cfg_cpus`, or 1 when `cfg_cpus` is 0 (no count configured).
- R5: A write to offset 0x08 selects line = write data bits 7:0. With `bus_size` 1 (two bytes) or larger, the line is driven to 1 if bits 15:8 are nonzero and to 0 otherwise. With `bus_size` 0 (one byte), the line is driven to 0. The level is held until the line is rewritten.
- R6: An interrupt write whose line number is at or above the effective processor count (per R4), or at or above NCPU, changes no interrupt line.
- R7: A read of offset 0x14 samples the console input. When `rx_valid` is 1 it returns 1 and captures `rx_data`. Otherwise it returns 0 and clears the captured character to 0.
- R8: A read of offset 0x10 returns the last captured character. A write to 0x10 overwrites it with write data bits 7:0.
- R9: A write to offset 0x18 pulses `tx_valid` for one cycle with `tx_data` equal to write data bits 7:0. The byte can then be read back at 0x18, and the transmit status at 0x1C becomes 1. Software may overwrite the transmit status by writing 0x1C.
- R10: Synchronous active-high reset clears all interrupt lines, `exit_code`, both strobes and the captured and transmitted bytes, and sets the transmit status to 1.
- R11: Reads of unmapped or write-only offsets (0x00, 0x08, 0x20 to 0x3F, non-word-aligned offsets) return 0. Writes to unmapped or read-only offsets change no output or readable state.
- R12: `bus_rdata` is registered: it carries the read result in the cycle after `bus_rd` and is 0 in any cycle not following a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | AW | Byte address; bits 5:0 decoded |
| bus_size | input | 2 | 0 one byte, 1 two bytes, 2 or 3 four bytes |
| bus_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| bus_cpu | input | CW | Index of the requesting processor |
| bus_rdata | output | 32 | Registered read data |
| cfg_cpus | input | 8 | Configured processor count, 0 = not set |
| irq_line | output | NCPU | Level interrupt line per processor |
| halt_pulse | output | 1 | One-cycle halt request |
| exit_code | output | 8 | Exit status of the last halt write |
| rx_valid | input | 1 | Console character available |
| rx_data | input | 8 | Console character |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmitted byte |

## Verification
The interrupt register carries most of the logic. It is driven with random line numbers, both in range and beyond the processor count, with random level bytes and all size codes, and the full line vector is compared with a bench model after each write. This separates correct line selection from neighbouring-line corruption, a zero level byte from a nonzero one, and two-byte writes from single-byte ones. Directed sequences cover the console paths: a character present versus absent at the status read, a software overwrite of the captured data, and a transmit status cleared and then set again by a send. Random upper address bits on every access expose any decode that looks beyond bit 5.

// File: rtl/fw_glue_regs.sv
module fw_glue_regs #(
  parameter int NCPU = 4,
  parameter int AW   = 16,
  localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [1:0]      bus_size,
  input  logic [31:0]     bus_wdata,
  input  logic [CW-1:0]   bus_cpu,
  output logic [31:0]     bus_rdata,
  input  logic [7:0]      cfg_cpus,
  output logic [NCPU-1:0] irq_line,
  output logic            halt_pulse,
  output logic [7:0]      exit_code,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  output logic            tx_valid,
  output logic [7:0]      tx_data
);
  localparam logic [5:0] O_HALT  = 6'h00;
  localparam logic [5:0] O_CPUID = 6'h04;
  localparam logic [5:0] O_IRQ   = 6'h08;
  localparam logic [5:0] O_COUNT = 6'h0C;
  localparam logic [5:0] O_RXD   = 6'h10;
  localparam logic [5:0] O_RXS   = 6'h14;
  localparam logic [5:0] O_TXD   = 6'h18;
  localparam logic [5:0] O_TXS   = 6'h1C;
  localparam logic [7:0] NCPU8   = 8'(NCPU);

  logic [5:0] off;
  logic [7:0] eff_cnt, line, rx_hold, tx_stat;
  logic       lvl, line_ok;
  logic [31:0] rd_val;

  assign off     = bus_addr[5:0];
  assign eff_cnt = (cfg_cpus == 8'd0) ? 8'd1 : cfg_cpus;
  assign line    = bus_wdata[7:0];
  assign lvl     = (bus_size != 2'd0) && (bus_wdata[15:8] != 8'd0);
  assign line_ok = (line < eff_cnt) && (line < NCPU8);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line <= '0;
    end else if (bus_wr && off == O_IRQ && line_ok) begin
      irq_line[line[CW-1:0]] <= lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_pulse <= 1'b0;
      exit_code  <= 8'd0;
      tx_valid   <= 1'b0;
      tx_data    <= 8'd0;
      tx_stat    <= 8'd1;
    end else begin
      halt_pulse <= bus_wr && off == O_HALT;
      tx_valid   <= bus_wr && off == O_TXD;
      if (bus_wr && off == O_HALT) exit_code <= bus_wdata[7:0];
      if (bus_wr && off == O_TXD) begin
        tx_data <= bus_wdata[7:0];
        tx_stat <= 8'd1;
      end
      if (bus_wr && off == O_TXS) tx_stat <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= 8'd0;
    end else if (bus_rd && off == O_RXS) begin
      rx_hold <= rx_valid ? rx_data : 8'd0;
    end else if (bus_wr && off == O_RXD) begin
      rx_hold <= bus_wdata[7:0];
    end
  end

  always_comb begin
    case (off)
      O_CPUID: rd_val = 32'(bus_cpu);
      O_COUNT: rd_val = {24'd0, eff_cnt};
      O_RXD:   rd_val = {24'd0, rx_hold};
      O_RXS:   rd_val = {31'd0, rx_valid};
      O_TXD:   rd_val = {24'd0, tx_data};
      O_TXS:   rd_val = {24'd0, tx_stat};
      default: rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 32'd0;
    else     bus_rdata <= bus_rd ? rd_val : 32'd0;
  end
endmodule

// File: rtl/fw_glue_regs_chk.sv
module fw_glue_regs_chk #(
  parameter int NCPU = 4,
  parameter int CW   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [5:0]      off,
  input logic [7:0]      wbyte,
  input logic [CW-1:0]   bus_cpu,
  input logic [31:0]     bus_rdata,
  input logic [NCPU-1:0] irq_line,
  input logic            halt_pulse,
  input logic [7:0]      exit_code,
  input logic            rx_valid,
  input logic            tx_valid,
  input logic [7:0]      tx_data
);
  p_halt_code_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 6'h00) |=> (halt_pulse && exit_code == $past(wbyte)));
  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && off == 6'h00) |=> !halt_pulse);
  p_cpu_index_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 6'h04) |=> bus_rdata == 32'($past(bus_cpu)));
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && off == 6'h08) |=> $stable(irq_line));
  p_rx_sample_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 6'h14) |=> bus_rdata == {31'd0, $past(rx_valid)});
  p_tx_send_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 6'h18) |=> (tx_valid && tx_data == $past(wbyte)));
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (irq_line == '0 && !halt_pulse && !tx_valid && exit_code == 8'd0));
  p_idle_rdata_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 32'd0);
endmodule

bind fw_glue_regs fw_glue_regs_chk #(.NCPU(NCPU), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .off(bus_addr[5:0]), .wbyte(bus_wdata[7:0]), .bus_cpu(bus_cpu),
  .bus_rdata(bus_rdata), .irq_line(irq_line), .halt_pulse(halt_pulse),
  .exit_code(exit_code), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_data(tx_data)
);

// File: tb/fw_glue_regs_tb.sv
module fw_glue_regs_tb;
  localparam int NCPU = 4;
  localparam int AW = 16;
  localparam int CW = 2;
  localparam time TCLK = 10ns;

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [CW-1:0] bus_cpu = 0;
  logic [7:0] cfg_cpus = 0, exit_code, rx_data = 0, tx_data;
  logic [NCPU-1:0] irq_line;
  logic halt_pulse, rx_valid = 0, tx_valid;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NCPU-1:0] irq_m = '0;

  always #(TCLK/2) clk = ~clk;

  fw_glue_regs #(.NCPU(NCPU), .AW(AW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] alias_addr(input logic [5:0] o);
    return {10'($urandom), o};
  endfunction

  function automatic logic [7:0] eff(input logic [7:0] c);
    return (c == 0) ? 8'd1 : c;
  endfunction

  task automatic wr(input logic [5:0] o, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = alias_addr(o); bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] o, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = alias_addr(o);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk(irq_line == 0, "R10 irq", 32'(irq_line), 0);
    chk(exit_code == 0, "R10 exit", 32'(exit_code), 0);
    rd(6'h1C, r); chk(r == 1, "R10 tx status", r, 1);
    rd(6'h18, r); chk(r == 0, "R10 tx data", r, 0);
    rd(6'h10, r); chk(r == 0, "R10 rx data", r, 0);
    // R12 idle
    @(negedge clk); chk(bus_rdata == 0, "R12 idle rdata", bus_rdata, 0);
    // R2 halt
    wr(6'h00, 2'd0, 32'h0000_00A5);
    chk(halt_pulse == 1, "R2 pulse", 32'(halt_pulse), 1);
    chk(exit_code == 8'hA5, "R2 code", 32'(exit_code), 32'hA5);
    @(negedge clk);
    chk(halt_pulse == 0, "R2 pulse one cycle", 32'(halt_pulse), 0);
    chk(exit_code == 8'hA5, "R2 code held", 32'(exit_code), 32'hA5);
    // R3 cpu id
    for (int c = 0; c < NCPU; c++) begin
      bus_cpu = CW'(c);
      rd(6'h04, r); chk(r == 32'(c), "R3 cpu id", r, 32'(c));
    end
    // R4 count
    cfg_cpus = 0; rd(6'h0C, r); chk(r == 1, "R4 unset count", r, 1);
    cfg_cpus = 3; rd(6'h0C, r); chk(r == 3, "R4 count", r, 3);
    // R11 unmapped / write-only reads and ignored writes
    rd(6'h00, r); chk(r == 0, "R11 read halt reg", r, 0);
    rd(6'h08, r); chk(r == 0, "R11 read irq reg", r, 0);
    rd(6'h24, r); chk(r == 0, "R11 read unmapped", r, 0);
    wr(6'h24, 2'd2, 32'hFFFF_FFFF);
    wr(6'h0C, 2'd2, 32'hFFFF_0001);
    wr(6'h04, 2'd2, 32'hFFFF_0001);
    chk(irq_line == 0 && !halt_pulse && !tx_valid, "R11 ignored write outputs", 32'(irq_line), 0);
    rd(6'h0C, r); chk(r == 3, "R11 count unchanged", r, 3);
    rd(6'h18, r); chk(r == 0, "R11 tx data unchanged", r, 0);
    // R5 directed: two-byte set, one-byte clears
    cfg_cpus = 4;
    wr(6'h08, 2'd1, 32'h0000_0102); irq_m[2] = 1;
    chk(irq_line == irq_m, "R5 two-byte set", 32'(irq_line), 32'(irq_m));
    wr(6'h08, 2'd0, 32'h0000_FF02); irq_m[2] = 0;
    chk(irq_line == irq_m, "R5 one-byte drives 0", 32'(irq_line), 32'(irq_m));
    // R6 out of range with count 2
    cfg_cpus = 2;
    wr(6'h08, 2'd1, 32'h0000_0103);
    chk(irq_line == irq_m, "R6 line above count", 32'(irq_line), 32'(irq_m));
    wr(6'h08, 2'd1, 32'h0000_0101); irq_m[1] = 1;
    chk(irq_line == irq_m, "R6 line in range", 32'(irq_line), 32'(irq_m));
    // R5/R6/R1 random
    for (int i = 0; i < 300; i++) begin
      logic [7:0] ln, lv;
      logic [1:0] sz;
      cfg_cpus = 8'($urandom_range(0, 6));
      ln = 8'($urandom_range(0, 7));
      lv = ($urandom_range(0, 2) == 0) ? 8'd0 : 8'($urandom);
      sz = 2'($urandom);
      wr(6'h08, sz, {16'($urandom), lv, ln});
      if (ln < eff(cfg_cpus) && ln < NCPU)
        irq_m[ln[CW-1:0]] = (sz != 0) && (lv != 0);
      chk(irq_line == irq_m, "R5 R6 R1 random irq", 32'(irq_line), 32'(irq_m));
    end
    // R7 / R8 console input
    rx_valid = 1; rx_data = 8'h41;
    rd(6'h14, r); chk(r == 1, "R7 status avail", r, 1);
    rx_valid = 0; rx_data = 8'h77;
    rd(6'h10, r); chk(r == 32'h41, "R7 captured", r, 32'h41);
    rd(6'h14, r); chk(r == 0, "R7 status empty", r, 0);
    rd(6'h10, r); chk(r == 0, "R7 cleared data", r, 0);
    wr(6'h10, 2'd0, 32'h0000_005A);
    rd(6'h10, r); chk(r == 32'h5A, "R8 overwrite", r, 32'h5A);
    // R9 transmit
    wr(6'h1C, 2'd0, 32'h0);
    rd(6'h1C, r); chk(r == 0, "R9 status cleared", r, 0);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      wr(6'h18, 2'd0, {24'($urandom), b});
      chk(tx_valid && tx_data == b, "R9 tx strobe", {23'd0, tx_valid, tx_data}, {23'd1, 1'b1, b});
      @(negedge clk);
      chk(!tx_valid, "R9 strobe one cycle", 32'(tx_valid), 0);
      rd(6'h18, r); chk(r == 32'(b), "R9 readback", r, 32'(b));
    end
    rd(6'h1C, r); chk(r == 1, "R9 status set", r, 1);
    // R10 reset again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(irq_line == 0 && exit_code == 0, "R10 second reset", 32'(irq_line), 0);
    finish_up();
  end
endmodule